// File: doc/BRIEF.md
# Two-stage sparse-multiple CRC-32 engine

This block produces the CRC-32 remainder of a byte stream with a split datapath. A fast front register, 123 bits wide, holds the running remainder of the message modulo a sparse polynomial that is an exact multiple of the CRC-32 generator. Its nonzero terms are spaced so widely that a whole byte can be folded in per clock with nothing deeper than a 2-input XOR on any bit. Only when the closing byte of a message arrives is the dense generator used. A back register then walks the 123-bit intermediate value one bit per clock and turns it into the final 32-bit remainder.

Bytes arrive with a valid and a last flag and are taken whenever the ready output is high. Ready drops during the 123-cycle reduction. It rises again in the same cycle that the one-cycle done pulse presents the result, so the next message can follow at once. The result is the plain remainder: the register starts at zero, no final inversion is applied, and no bits are reflected.

Top module: `crc2_engine`

## Requirements
- R1: After reset, `in_ready` is 1, `crc_done` is 0 and `crc_out` is 0.
- R2: A byte is taken on a rising clock edge where `in_valid` and `in_ready` are both 1. Bit 7 of each byte is the earliest, highest-order message coefficient, and earlier bytes precede later ones.
- R3: `crc_out` equals M(x)·x^32 mod G(x), where G(x) is the generator 0x104C11DB7 written msbit-first. The register starts at zero and is not inverted. Bit 31 of `crc_out` holds the coefficient of x^31.
- R4: `crc_done` is high for exactly one cycle. It rises 123 clock edges after the edge that takes a byte with `in_last` = 1.
- R5: `in_ready` is 0 from the edge that takes the closing byte until the edge that raises `crc_done`. Bytes presented while it is 0, with or without `in_last`, change neither the result nor the timing.
- R6: `crc_out` keeps its value at all times except on the edge that raises `crc_done`.
- R7: Each message starts from a zero remainder. A new message may begin in the very cycle that `crc_done` is high, and its result is independent of earlier messages.
- R8: Cycles with `in_valid` = 0, placed between the bytes of a message, do not change the result.
- R9: The result is correct for messages longer than the 123-bit front register (16 bytes or more) as well as for single-byte messages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_byte | input | 8 | Message byte, bit 7 first |
| in_valid | input | 1 | `in_byte` holds a byte of the message |
| in_last | input | 1 | Current byte closes the message |
| in_ready | output | 1 | Engine can take a byte this cycle |
| crc_out | output | 32 | Remainder of the latest finished message |
| crc_done | output | 1 | One-cycle pulse: `crc_out` has just been updated |

## Verification
The hardest condition to reach is feedback inside the front register. No tap of the sparse multiple fires until more than 123 message bits have entered, so short messages never exercise the reduction terms at all. The stimulus therefore mixes single-byte messages with random lengths up to 40 bytes and includes directed 16-, 17- and 32-byte messages of all-ones. Random idle gaps between bytes, junk bytes with the last flag held on throughout the reduction window, and messages started in the same cycle as the done pulse cover the gap-tolerance and back-to-back rules.

// File: rtl/crc2_pkg.sv
package crc2_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned MID_W  = 123;
  localparam int unsigned CRC_W  = 32;

  // Sparse multiple of the CRC-32 generator, leading x^123 implied.
  localparam logic [MID_W-1:0] MID_TAPS =
      (MID_W'(1) << 111) | (MID_W'(1) << 92) | (MID_W'(1) << 84) |
      (MID_W'(1) << 64)  | (MID_W'(1) << 46) | (MID_W'(1) << 23) |
      MID_W'(1);

  // Dense CRC-32 generator, msbit-first, leading x^32 implied.
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
endpackage

// File: rtl/crc2_sparse_front.sv
module crc2_sparse_front #(
  parameter int unsigned        DW   = 8,
  parameter int unsigned        RW   = 123,
  parameter logic [RW-1:0]      TAPS = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          clear,
  input  logic [DW-1:0] din,
  output logic [RW-1:0] rem_q,
  output logic [RW-1:0] rem_nxt
);
  // Plain long division: each bit shifts in at the bottom and the bit
  // leaving the top folds the taps back in.
  always_comb begin
    logic [RW-1:0] r;
    logic          top;
    r = rem_q;
    for (int k = DW - 1; k >= 0; k--) begin
      top = r[RW-1];
      r   = {r[RW-2:0], din[k]};
      if (top) r = r ^ TAPS;
    end
    rem_nxt = r;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) rem_q <= '0;
    else if (take)    rem_q <= rem_nxt;
  end

  // R8: without a taken byte the remainder stays put
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(rem_q));
endmodule

// File: rtl/crc2_dense_reduce.sv
module crc2_dense_reduce #(
  parameter int unsigned   IW   = 123,
  parameter int unsigned   CW   = 32,
  parameter logic [CW-1:0] POLY = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [IW-1:0] load_val,
  output logic          busy,
  output logic [CW-1:0] crc_out,
  output logic          done
);
  localparam int unsigned CNT_W = $clog2(IW + 1);

  logic [IW-1:0]    sh;
  logic [CW-1:0]    acc;
  logic [CW-1:0]    acc_nxt;
  logic [CNT_W-1:0] cnt;
  logic             fb;

  // Deferred-XOR serial division over the intermediate bits, top first.
  always_comb begin
    fb      = acc[CW-1] ^ sh[IW-1];
    acc_nxt = {acc[CW-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      acc     <= '0;
      cnt     <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      crc_out <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        sh   <= load_val;
        acc  <= '0;
        cnt  <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        acc <= acc_nxt;
        sh  <= sh << 1;
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(IW - 1)) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          crc_out <= acc_nxt;
        end
      end
    end
  end

  assert_done_after_busy_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));
  assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt < CNT_W'(IW)));
  assert_result_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(crc_out));
  assert_no_reload_R5: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy);
endmodule

// File: rtl/crc2_engine.sv
module crc2_engine #(
  parameter int unsigned                   DW   = crc2_pkg::BYTE_W,
  parameter int unsigned                   IW   = crc2_pkg::MID_W,
  parameter int unsigned                   CW   = crc2_pkg::CRC_W,
  parameter logic [IW-1:0]                 TAPS = crc2_pkg::MID_TAPS,
  parameter logic [CW-1:0]                 POLY = crc2_pkg::CRC_POLY
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] in_byte,
  input  logic          in_valid,
  input  logic          in_last,
  output logic          in_ready,
  output logic [CW-1:0] crc_out,
  output logic          crc_done
);
  logic          red_busy;
  logic          take;
  logic          take_last;
  logic [IW-1:0] front_rem;
  logic [IW-1:0] front_nxt;

  assign in_ready  = !red_busy;
  assign take      = in_valid && in_ready;
  assign take_last = take && in_last;

  crc2_sparse_front #(.DW(DW), .RW(IW), .TAPS(TAPS)) u_front (
    .clk     (clk),
    .rst     (rst),
    .take    (take),
    .clear   (take_last),
    .din     (in_byte),
    .rem_q   (front_rem),
    .rem_nxt (front_nxt)
  );

  crc2_dense_reduce #(.IW(IW), .CW(CW), .POLY(POLY)) u_reduce (
    .clk      (clk),
    .rst      (rst),
    .load     (take_last),
    .load_val (front_nxt),
    .busy     (red_busy),
    .crc_out  (crc_out),
    .done     (crc_done)
  );

  assert_start_on_last_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(red_busy) |-> $past(in_valid && in_last));
  assert_front_cleared_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(red_busy) |-> (front_rem == '0));
  assert_ready_with_done_R7: assert property (@(posedge clk) disable iff (rst)
    crc_done |-> in_ready);
endmodule

// File: tb/crc2_engine_test.sv
module crc2_engine_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  in_byte = '0;
  logic        in_valid = 1'b0;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic [31:0] crc_out;
  logic        crc_done;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  logic [7:0]  msg [0:63];
  logic [31:0] prev_crc = '0;
  int unsigned seed_dummy;

  always #2.5 clk = ~clk;

  crc2_engine uut (
    .clk(clk), .rst(rst), .in_byte(in_byte), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .crc_out(crc_out),
    .crc_done(crc_done)
  );

  function automatic logic [31:0] model_crc(int n);
    logic [31:0] c = '0;
    logic fb;
    for (int i = 0; i < n; i++)
      for (int b = 7; b >= 0; b--) begin
        fb = c[31] ^ msg[i][b];
        c  = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C11DB7;
      end
    return c;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Sends msg[0:n-1]; returns 1 ns after the edge raising crc_done.
  task automatic run_msg(int n, int max_gap, bit junk, string req);
    logic [31:0] exp;
    bit bad_busy = 0;
    bit bad_hold = 0;
    exp = model_crc(n);
    for (int i = 0; i < n; i++) begin
      int gap;
      gap = (max_gap > 0) ? int'($urandom_range(max_gap)) : 0;
      for (int g = 0; g < gap; g++) begin
        in_valid = 1'b0;
        in_byte  = 8'($urandom);
        @(posedge clk); #1;
      end
      in_valid = 1'b1;
      in_byte  = msg[i];
      in_last  = (i == n - 1);
      @(posedge clk); #1;
    end
    in_valid = junk;
    in_byte  = 8'hA5;
    in_last  = 1'b1;
    for (int k = 0; k < 122; k++) begin
      @(posedge clk); #1;
      if (crc_done || in_ready) bad_busy = 1;
      if (crc_out !== prev_crc) bad_hold = 1;
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    check(!bad_busy, "R4/R5 busy window", {31'd0, bad_busy}, 32'd0);
    check(!bad_hold, "R6 hold during reduction", crc_out, prev_crc);
    @(posedge clk); #1;
    check(crc_done === 1'b1, "R4 done at edge 123", {31'd0, crc_done}, 32'd1);
    check(in_ready === 1'b1, "R7 ready with done", {31'd0, in_ready}, 32'd1);
    check(crc_out === exp, req, crc_out, exp);
    prev_crc = exp;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    seed_dummy = $urandom(32'h5EED_C0DE);
    repeat (3) @(posedge clk);
    #1;
    check(in_ready === 1'b1, "R1 ready", {31'd0, in_ready}, 32'd1);
    check(crc_done === 1'b0, "R1 done", {31'd0, crc_done}, 32'd0);
    check(crc_out === 32'd0, "R1 crc", crc_out, 32'd0);
    rst = 1'b0;
    @(posedge clk); #1;

    // R2: single byte, msbit first
    msg[0] = 8'h80;
    run_msg(1, 0, 0, "R2 single 0x80");
    @(posedge clk); #1;
    check(crc_done === 1'b0, "R4 single pulse", {31'd0, crc_done}, 32'd0);
    msg[0] = 8'h01;
    run_msg(1, 0, 0, "R2 single 0x01");
    msg[0] = 8'h00;
    run_msg(1, 0, 0, "R9 single zero");

    // R9: lengths around and beyond 123 bits, all ones
    for (int i = 0; i < 32; i++) msg[i] = 8'hFF;
    run_msg(16, 0, 0, "R9 16 bytes ones");
    run_msg(17, 0, 0, "R9 17 bytes ones");
    run_msg(32, 0, 0, "R9 32 bytes ones");

    // R5: junk bytes with last held on during reduction
    for (int i = 0; i < 20; i++) msg[i] = 8'(i * 37 + 11);
    run_msg(20, 0, 1, "R5 junk during reduction");
    run_msg(3, 0, 0, "R7 after junk, clean start");

    // R6: idle, no spurious done, value held
    begin
      bit spurious = 0;
      for (int k = 0; k < 130; k++) begin
        @(posedge clk); #1;
        if (crc_done || crc_out !== prev_crc) spurious = 1;
      end
      check(!spurious, "R6 idle hold", crc_out, prev_crc);
    end

    // R3/R7/R8: random messages, back to back, random gaps
    for (int t = 0; t < 30; t++) begin
      int n;
      n = int'($urandom_range(40, 1));
      for (int i = 0; i < n; i++) msg[i] = 8'($urandom);
      run_msg(n, (t % 2) ? 3 : 0, t[2], (t % 2) ? "R8 gaps random" : "R3 random b2b");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule